// File: doc/BRIEF.md
# Debug Probe Command Stream Parser

This block sits between a host link and a serial-wire debug engine inside a debug probe. It takes one host transaction as a stream of 32-bit words and first checks the opening word. It then walks the messages that follow. Each message is a header word that holds a command byte, an operation byte and a 16-bit argument, and the header may be followed by payload words. The block turns each command into register-access requests on a single-outstanding request/acknowledge port toward the engine. It returns read results as reply words, and it closes every transaction with one status word.

Errors are sticky. The first fault stops command processing: a bad opener, an over-long transaction, a truncated payload, an unknown command or an error reported by the engine. The remaining input words are then swallowed until the end-of-transaction flag. The status word carries the error code and the number of commands that completed before the fault.

Top module: `probe_cmd_parser`

## Requirements
- R1: The first word of a transaction must be either `0xAA77ssss` (any 16-bit sequence `ssss`) or exactly `0xAA001111`. Any other first word sets error code 1, issues no request and drains the rest of the transaction.
- R2: A header holds the command in bits 31:24, the operation in bits 23:16 and the argument in bits 15:0. Command 0x00 is padding: it is skipped whatever its other bits hold, it takes no payload and it is not counted.
- R3: Command 0x01 with count N in the argument takes N data words. Each word gives one request with reqWrite=1, reqAp equal to operation bit 1, reqReg equal to operation bits 3:2 and reqWdata equal to the word. Operation bit 0 has no effect.
- R4: Command 0x02 with count N first emits reply header `0x1100NNNN`. It then issues N read requests (reqWrite=0, same reqAp/reqReg mapping as R3) and forwards each rdData as a reply word, in order.
- R5: Command 0x03 with count N issues N read requests and emits no reply words.
- R6: Command 0x06 with count N takes one address word and then N data words. The address gives an access-port write to register 1, and each data word gives an access-port write to register 3.
- R7: After the word flagged last, the block emits exactly one status word `0x10EECCCC`. EE is the error code and CCCC is the number of non-padding commands completed. It follows all reply words of the transaction, and the block then waits for a new opener.
- R8: A transaction may hold 1024 words, opener included. The 1025th word sets error code 1.
- R9: If the last-flagged word arrives while a write or download still expects payload, error code 1 is set and no further request is made.
- R10: An unrecognised command byte sets error code 1, the remaining words are drained, and the count stops.
- R11: The first non-zero reqErr seen with reqAck becomes the error code and is never overwritten. No request follows it, the failing command is not counted, and the rest is drained.
- R12: reqValid holds with stable fields until reqAck. outValid holds with stable outData until outReady. inReady, reqValid and outValid are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 32 | Transaction word |
| inValid | input | 1 | inData is valid |
| inLast | input | 1 | Word is the last of the transaction |
| inReady | output | 1 | Word is accepted when high with inValid |
| reqValid | output | 1 | Access request pending |
| reqAck | input | 1 | Engine completes the pending request |
| reqErr | input | 3 | Engine error code, sampled with reqAck (0 = none) |
| reqWrite | output | 1 | Request is a write |
| reqAp | output | 1 | 1 = access port, 0 = debug port |
| reqReg | output | 2 | Register offset index (offset = 4 x value) |
| reqWdata | output | 32 | Write data |
| rdData | input | 32 | Read result, sampled with reqAck |
| outData | output | 32 | Reply word |
| outValid | output | 1 | Reply word valid |
| outReady | input | 1 | Consumer takes the reply word |

## Verification
The bench drives transactions whose last flag falls exactly on the final expected payload word, one word early, and on a bare header. A parser that counts payload off by one would then either issue a spurious request or report a truncation that did not happen. It sends exactly 1024 and 1025 words to pin the length limit, and it checks that padding with non-zero operation and argument fields stays invisible. It injects an engine error mid-write, so any design that keeps issuing requests, overwrites the code or counts the failing command shows up in the request and status streams. Reply back-pressure is applied throughout, so reordering or dropping of read results is caught by the ordered reply check.

// File: rtl/probe_pkg.sv
package probe_pkg;
  localparam int CNT_W = 16;

  localparam logic [15:0] SYNC_TAG   = 16'hAA77;
  localparam logic [31:0] ASYNC_WORD = 32'hAA001111;

  localparam logic [7:0] CMD_PAD  = 8'h00;
  localparam logic [7:0] CMD_WR   = 8'h01;
  localparam logic [7:0] CMD_RD   = 8'h02;
  localparam logic [7:0] CMD_RDX  = 8'h03;
  localparam logic [7:0] CMD_DL   = 8'h06;
  localparam logic [7:0] RPL_STAT = 8'h10;
  localparam logic [7:0] RPL_DATA = 8'h11;

  localparam logic [2:0] ERR_INTERNAL = 3'd1;

  typedef enum logic [1:0] {OUT_STAT, OUT_RHDR, OUT_RDAT} outSel_e;

  typedef struct packed {
    logic       openTxn;
    logic       takeWord;
    logic       loadHdr;
    logic       takeData;
    logic       takeRd;
    logic       decRemain;
    logic       incCmd;
    logic       setErr;
    logic [2:0] errCode;
    logic       addrPhase;
    outSel_e    outSel;
  } ctlStrobe_t;
endpackage

// File: rtl/probe_dp.sv
module probe_dp
  import probe_pkg::*;
#(
  parameter int MAX_WORDS = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic [31:0]      inData,
  input  logic             inLast,
  input  logic [31:0]      rdData,
  output logic [7:0]       hdrCmd,
  output logic             remainIsOne,
  output logic             remainIsZero,
  output logic             lastSeen,
  output logic             wordsFull,
  output logic [7:0]       errCode,
  output logic             reqWrite,
  output logic             reqAp,
  output logic [1:0]       reqReg,
  output logic [31:0]      reqWdata,
  output logic [31:0]      outData
);
  localparam int WC_W = $clog2(MAX_WORDS + 1);

  logic [7:0]       cmdR;
  logic             apR;
  logic [1:0]       regR;
  logic [CNT_W-1:0] argR;
  logic [CNT_W-1:0] remR;
  logic [CNT_W-1:0] cmdCnt;
  logic [WC_W-1:0]  wordCnt;
  logic [7:0]       errR;
  logic             lastR;
  logic [31:0]      dataR;
  logic [31:0]      rdR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdR    <= CMD_PAD;
      apR     <= 1'b0;
      regR    <= '0;
      argR    <= '0;
      remR    <= '0;
      cmdCnt  <= '0;
      wordCnt <= '0;
      errR    <= '0;
      lastR   <= 1'b0;
      dataR   <= '0;
      rdR     <= '0;
    end else begin
      if (ctl.takeWord) lastR <= inLast;
      if (ctl.openTxn) begin
        wordCnt <= WC_W'(1);
        cmdCnt  <= '0;
      end else if (ctl.takeWord && !ctl.setErr && errR == 8'd0) begin
        wordCnt <= wordCnt + 1'b1;
      end
      if (ctl.setErr && (errR == 8'd0 || ctl.openTxn)) errR <= {5'd0, ctl.errCode};
      else if (ctl.openTxn) errR <= '0;
      if (ctl.loadHdr) begin
        cmdR <= inData[31:24];
        apR  <= inData[17];
        regR <= inData[19:18];
        argR <= inData[CNT_W-1:0];
        remR <= inData[CNT_W-1:0];
      end else if (ctl.decRemain) begin
        remR <= remR - 1'b1;
      end
      if (ctl.takeData) dataR <= inData;
      if (ctl.takeRd)   rdR   <= rdData;
      if (ctl.incCmd)   cmdCnt <= cmdCnt + 1'b1;
    end
  end

  assign hdrCmd       = cmdR;
  assign remainIsOne  = (remR == CNT_W'(1));
  assign remainIsZero = (remR == '0);
  assign lastSeen     = lastR;
  assign wordsFull    = (wordCnt >= WC_W'(MAX_WORDS));
  assign errCode      = errR;

  // Download traffic is forced to access-port writes, address then data register
  always_comb begin
    reqWrite = (cmdR == CMD_WR) || (cmdR == CMD_DL);
    if (cmdR == CMD_DL) begin
      reqAp  = 1'b1;
      reqReg = ctl.addrPhase ? 2'd1 : 2'd3;
    end else begin
      reqAp  = apR;
      reqReg = regR;
    end
  end
  assign reqWdata = dataR;

  always_comb begin
    unique case (ctl.outSel)
      OUT_RHDR: outData = {RPL_DATA, 8'h00, argR};
      OUT_RDAT: outData = rdR;
      default:  outData = {RPL_STAT, errR, cmdCnt};
    endcase
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    wordCnt <= WC_W'(MAX_WORDS)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errR != 8'd0 && !ctl.openTxn) |=> errR == $past(errR)); // R11
endmodule

// File: rtl/probe_ctl.sv
module probe_ctl
  import probe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] inData,
  input  logic        inValid,
  input  logic        inLast,
  output logic        inReady,
  output logic        reqValid,
  input  logic        reqAck,
  input  logic [2:0]  reqErr,
  output logic        outValid,
  input  logic        outReady,
  input  logic [7:0]  hdrCmd,
  input  logic        remainIsOne,
  input  logic        remainIsZero,
  input  logic        lastSeen,
  input  logic        wordsFull,
  input  logic [7:0]  errCode,
  output ctlStrobe_t  ctl
);
  typedef enum logic [3:0] {
    S_OPEN, S_HDR, S_WDATA, S_DADDR, S_REQ, S_AREQ, S_RHDR, S_RDAT, S_DRAIN, S_STAT
  } state_e;

  state_e state, nextState;
  logic   openerOk;
  logic   argZero;

  assign openerOk = (inData[31:16] == SYNC_TAG) || (inData == ASYNC_WORD);
  assign argZero  = (inData[CNT_W-1:0] == '0);

  always_comb begin
    ctl       = '0;
    ctl.outSel = OUT_STAT;
    inReady   = 1'b0;
    reqValid  = 1'b0;
    outValid  = 1'b0;
    nextState = state;
    unique case (state)
      S_OPEN: begin
        inReady = 1'b1;
        if (inValid) begin
          ctl.takeWord = 1'b1;
          ctl.openTxn  = 1'b1;
          if (openerOk) nextState = inLast ? S_STAT : S_HDR;
          else begin
            ctl.setErr = 1'b1; ctl.errCode = ERR_INTERNAL;
            nextState = inLast ? S_STAT : S_DRAIN;
          end
        end
      end
      S_HDR: begin
        inReady = 1'b1;
        if (inValid) begin
          ctl.takeWord = 1'b1;
          if (wordsFull) begin
            ctl.setErr = 1'b1; ctl.errCode = ERR_INTERNAL;
            nextState = inLast ? S_STAT : S_DRAIN;
          end else begin
            ctl.loadHdr = 1'b1;
            unique case (inData[31:24])
              CMD_PAD: nextState = inLast ? S_STAT : S_HDR;
              CMD_WR: begin
                if (argZero) begin
                  ctl.incCmd = 1'b1;
                  nextState = inLast ? S_STAT : S_HDR;
                end else if (inLast) begin
                  ctl.setErr = 1'b1; ctl.errCode = ERR_INTERNAL;
                  nextState = S_STAT;
                end else nextState = S_WDATA;
              end
              CMD_RD: nextState = S_RHDR;
              CMD_RDX: begin
                if (argZero) begin
                  ctl.incCmd = 1'b1;
                  nextState = inLast ? S_STAT : S_HDR;
                end else nextState = S_REQ;
              end
              CMD_DL: begin
                if (inLast) begin
                  ctl.setErr = 1'b1; ctl.errCode = ERR_INTERNAL;
                  nextState = S_STAT;
                end else nextState = S_DADDR;
              end
              default: begin
                ctl.setErr = 1'b1; ctl.errCode = ERR_INTERNAL;
                nextState = inLast ? S_STAT : S_DRAIN;
              end
            endcase
          end
        end
      end
      S_WDATA, S_DADDR: begin
        inReady = 1'b1;
        if (inValid) begin
          ctl.takeWord = 1'b1;
          if (wordsFull) begin
            ctl.setErr = 1'b1; ctl.errCode = ERR_INTERNAL;
            nextState = inLast ? S_STAT : S_DRAIN;
          end else begin
            ctl.takeData = 1'b1;
            nextState = (state == S_DADDR) ? S_AREQ : S_REQ;
          end
        end
      end
      S_REQ, S_AREQ: begin
        reqValid      = 1'b1;
        ctl.addrPhase = (state == S_AREQ);
        if (reqAck) begin
          if (reqErr != 3'd0) begin
            ctl.setErr = 1'b1; ctl.errCode = reqErr;
            nextState = lastSeen ? S_STAT : S_DRAIN;
          end else if (state == S_AREQ) begin
            if (remainIsZero) begin
              ctl.incCmd = 1'b1;
              nextState = lastSeen ? S_STAT : S_HDR;
            end else if (lastSeen) begin
              ctl.setErr = 1'b1; ctl.errCode = ERR_INTERNAL;
              nextState = S_STAT;
            end else nextState = S_WDATA;
          end else begin
            ctl.decRemain = 1'b1;
            if (hdrCmd == CMD_RD) begin
              ctl.takeRd = 1'b1;
              nextState = S_RDAT;
            end else if (remainIsOne) begin
              ctl.incCmd = 1'b1;
              nextState = lastSeen ? S_STAT : S_HDR;
            end else if (hdrCmd == CMD_RDX) begin
              nextState = S_REQ;
            end else if (lastSeen) begin
              ctl.setErr = 1'b1; ctl.errCode = ERR_INTERNAL;
              nextState = S_STAT;
            end else nextState = S_WDATA;
          end
        end
      end
      S_RHDR, S_RDAT: begin
        outValid   = 1'b1;
        ctl.outSel = (state == S_RHDR) ? OUT_RHDR : OUT_RDAT;
        if (outReady) begin
          if (remainIsZero) begin
            ctl.incCmd = 1'b1;
            nextState = lastSeen ? S_STAT : S_HDR;
          end else nextState = S_REQ;
        end
      end
      S_DRAIN: begin
        inReady = 1'b1;
        if (inValid) begin
          ctl.takeWord = 1'b1;
          if (inLast) nextState = S_STAT;
        end
      end
      default: begin
        outValid = 1'b1;
        if (outReady) nextState = S_OPEN;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_OPEN;
    else       state <= nextState;
  end

  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({inReady, reqValid, outValid})); // R12
  AST_NO_REQ_AFTER_ERR: assert property (@(posedge clk) disable iff (!rstN)
    errCode != 8'd0 |-> !reqValid); // R11
endmodule

// File: rtl/probe_cmd_parser.sv
module probe_cmd_parser
  import probe_pkg::*;
#(
  parameter int MAX_WORDS = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] inData,
  input  logic        inValid,
  input  logic        inLast,
  output logic        inReady,
  output logic        reqValid,
  input  logic        reqAck,
  input  logic [2:0]  reqErr,
  output logic        reqWrite,
  output logic        reqAp,
  output logic [1:0]  reqReg,
  output logic [31:0] reqWdata,
  input  logic [31:0] rdData,
  output logic [31:0] outData,
  output logic        outValid,
  input  logic        outReady
);
  ctlStrobe_t ctl;
  logic [7:0] hdrCmd;
  logic [7:0] errCode;
  logic       remainIsOne, remainIsZero, lastSeen, wordsFull;

  probe_ctl u_ctl (
    .clk(clk), .rstN(rstN),
    .inData(inData), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .reqValid(reqValid), .reqAck(reqAck), .reqErr(reqErr),
    .outValid(outValid), .outReady(outReady),
    .hdrCmd(hdrCmd), .remainIsOne(remainIsOne), .remainIsZero(remainIsZero),
    .lastSeen(lastSeen), .wordsFull(wordsFull), .errCode(errCode),
    .ctl(ctl)
  );

  probe_dp #(.MAX_WORDS(MAX_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .inData(inData), .inLast(inLast), .rdData(rdData),
    .hdrCmd(hdrCmd), .remainIsOne(remainIsOne), .remainIsZero(remainIsZero),
    .lastSeen(lastSeen), .wordsFull(wordsFull), .errCode(errCode),
    .reqWrite(reqWrite), .reqAp(reqAp), .reqReg(reqReg), .reqWdata(reqWdata),
    .outData(outData)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqAck) |=> reqValid && $stable({reqWrite, reqAp, reqReg, reqWdata})); // R12
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outData)); // R12
endmodule

// File: tb/sim_probe_cmd_parser.sv
`timescale 1ns/1ps
module sim_probe_cmd_parser;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] inData = '0;
  logic        inValid = 1'b0, inLast = 1'b0;
  logic        inReady, reqValid, reqWrite, reqAp, outValid;
  logic        reqAck = 1'b0;
  logic [2:0]  reqErr = '0;
  logic [1:0]  reqReg;
  logic [31:0] reqWdata, outData;
  logic [31:0] rdData = '0;
  logic        outReady = 1'b0;

  always #2 clk = ~clk;

  probe_cmd_parser u0 (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .reqValid(reqValid), .reqAck(reqAck), .reqErr(reqErr),
    .reqWrite(reqWrite), .reqAp(reqAp), .reqReg(reqReg), .reqWdata(reqWdata),
    .rdData(rdData), .outData(outData), .outValid(outValid), .outReady(outReady)
  );

  typedef struct {
    logic [35:0] v;
    string       tag;
  } item_t;

  item_t reqQ[$];
  item_t outQ[$];
  int checks = 0, fails = 0;
  int reqIdx = 0, rdNum = 0, expRd = 0, errAt = -1, waitCnt = 0, cyc = 0;
  logic [2:0] errVal = 3'd0;

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expReq(input logic w, input logic ap, input logic [1:0] rg, input logic [31:0] d, input string tag);
    item_t it;
    it.v = {w, ap, rg, d};
    it.tag = tag;
    reqQ.push_back(it);
  endtask

  task automatic expOut(input logic [31:0] d, input string tag);
    item_t it;
    it.v = {4'h0, d};
    it.tag = tag;
    outQ.push_back(it);
  endtask

  task automatic expRead(input logic ap, input logic [1:0] rg, input bit reply, input string tag);
    expReq(1'b0, ap, rg, 32'h0, tag);
    if (reply) expOut(32'hC0DE0000 + 32'(expRd), tag);
    expRd++;
  endtask

  task automatic expStatus(input logic [7:0] err, input logic [15:0] cnt, input string tag);
    expOut({8'h10, err, cnt}, tag);
  endtask

  task automatic sendWord(input logic [31:0] d, input logic l);
    inData = d; inValid = 1'b1; inLast = l;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic waitIdle(input string tag);
    int t = 0;
    while ((reqQ.size() != 0 || outQ.size() != 0) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    check(reqQ.size() == 0 && outQ.size() == 0, {tag, " all expected items seen"},
          36'(reqQ.size() + outQ.size()), 36'd0);
    check(inReady == 1'b1 && !reqValid && !outValid, {tag, " idle, awaiting opener (R7)"},
          {33'd0, inReady, reqValid, outValid}, 36'h4);
  endtask

  // Engine model and request monitor
  always @(negedge clk) begin
    if (!rstN) begin
      reqAck = 1'b0; waitCnt = 0;
    end else if (reqAck) begin
      reqAck = 1'b0; reqErr = 3'd0;
    end else if (reqValid) begin
      if (waitCnt < reqIdx % 3) waitCnt++;
      else begin
        item_t e;
        logic [35:0] act;
        waitCnt = 0;
        act = {reqWrite, reqAp, reqReg, reqWrite ? reqWdata : 32'h0};
        if (reqQ.size() == 0) check(1'b0, "R11 R12 unexpected request", act, 36'h0);
        else begin
          e = reqQ.pop_front();
          check(act == e.v, {e.tag, " request"}, act, e.v);
        end
        reqAck = 1'b1;
        reqErr = (reqIdx == errAt) ? errVal : 3'd0;
        rdData = 32'hC0DE0000 + 32'(rdNum);
        if (!reqWrite) rdNum++;
        reqIdx++;
      end
    end
  end

  // Reply monitor with back-pressure
  always @(negedge clk) begin
    cyc++;
    outReady = (cyc % 5 != 2) && (cyc % 7 != 3);
    if (rstN && outValid && outReady) begin
      item_t e;
      if (outQ.size() == 0) check(1'b0, "R7 unexpected reply", {4'h0, outData}, 36'h0);
      else begin
        e = outQ.pop_front();
        check({4'h0, outData} == e.v, {e.tag, " reply"}, {4'h0, outData}, e.v);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1 reset inReady", {35'd0, inReady}, 36'd1);
    check(!reqValid && !outValid, "R12 reset no request/reply", {34'd0, reqValid, outValid}, 36'd0);

    // R3 writes, op bit0 ignored; R2 padding with junk fields
    expReq(1, 1, 2'd1, 32'h1111_0001, "R3");
    expReq(1, 1, 2'd1, 32'h1111_0002, "R3");
    expReq(1, 0, 2'd3, 32'h2222_0003, "R3");
    expStatus(8'h00, 16'd2, "R2 R7");
    sendWord(32'hAA77_0005, 0);
    sendWord({8'h01, 8'h06, 16'd2}, 0);
    sendWord(32'h1111_0001, 0);
    sendWord(32'h1111_0002, 0);
    sendWord(32'h0012_3456, 0);
    sendWord({8'h01, 8'h0D, 16'd1}, 0);
    sendWord(32'h2222_0003, 0);
    sendWord(32'h00FF_0003, 1);
    waitIdle("R3");

    // R4 read with replies, R5 discard, async opener
    expOut(32'h1100_0003, "R4");
    for (int i = 0; i < 3; i++) expRead(0, 2'd3, 1, "R4");
    for (int i = 0; i < 2; i++) expRead(1, 2'd1, 0, "R5");
    expStatus(8'h00, 16'd2, "R4 R5 R7");
    sendWord(32'hAA00_1111, 0);
    sendWord({8'h02, 8'h0C, 16'd3}, 0);
    sendWord({8'h03, 8'h06, 16'd2}, 1);
    waitIdle("R4");

    // R6 download
    expReq(1, 1, 2'd1, 32'h2000_0000, "R6");
    expReq(1, 1, 2'd3, 32'h0000_0011, "R6");
    expReq(1, 1, 2'd3, 32'h0000_0022, "R6");
    expStatus(8'h00, 16'd1, "R6 R7");
    sendWord(32'hAA77_FFFF, 0);
    sendWord({8'h06, 8'h00, 16'd2}, 0);
    sendWord(32'h2000_0000, 0);
    sendWord(32'h0000_0011, 0);
    sendWord(32'h0000_0022, 1);
    waitIdle("R6");

    // R1 bad openers
    expStatus(8'h01, 16'd0, "R1");
    sendWord(32'hAA78_0000, 0);
    sendWord({8'h01, 8'h00, 16'd1}, 0);
    sendWord(32'h5555_5555, 1);
    waitIdle("R1");
    expStatus(8'h01, 16'd0, "R1");
    sendWord(32'hAA00_1112, 1);
    waitIdle("R1");

    // R9 truncated write and truncated download
    expReq(1, 0, 2'd0, 32'h0000_00A1, "R9");
    expReq(1, 0, 2'd0, 32'h0000_00A2, "R9");
    expStatus(8'h01, 16'd0, "R9");
    sendWord(32'hAA77_0001, 0);
    sendWord({8'h01, 8'h00, 16'd3}, 0);
    sendWord(32'h0000_00A1, 0);
    sendWord(32'h0000_00A2, 1);
    waitIdle("R9");
    expStatus(8'h01, 16'd0, "R9");
    sendWord(32'hAA77_0002, 0);
    sendWord({8'h06, 8'h00, 16'd1}, 1);
    waitIdle("R9");

    // R10 unknown command
    expReq(1, 0, 2'd1, 32'h0BAD_0001, "R10");
    expStatus(8'h01, 16'd1, "R10");
    sendWord(32'hAA77_0003, 0);
    sendWord({8'h01, 8'h04, 16'd1}, 0);
    sendWord(32'h0BAD_0001, 0);
    sendWord(32'h0700_0000, 0);
    sendWord({8'h01, 8'h00, 16'd1}, 0);
    sendWord(32'h0BAD_0002, 1);
    waitIdle("R10");

    // R11 engine error on second request
    errAt = reqIdx + 1; errVal = 3'd3;
    expRead(0, 2'd0, 0, "R11");
    expReq(1, 0, 2'd2, 32'hE000_0001, "R11");
    expStatus(8'h03, 16'd1, "R11");
    sendWord(32'hAA77_0004, 0);
    sendWord({8'h03, 8'h00, 16'd1}, 0);
    sendWord({8'h01, 8'h08, 16'd3}, 0);
    sendWord(32'hE000_0001, 0);
    sendWord(32'hE000_0002, 0);
    sendWord(32'hE000_0003, 0);
    sendWord({8'h01, 8'h00, 16'd1}, 0);
    sendWord(32'hE000_0004, 1);
    waitIdle("R11");
    errAt = -1;

    // R8 length limit: 1024 words accepted, 1025 rejected
    expStatus(8'h00, 16'd0, "R8");
    sendWord(32'hAA77_0010, 0);
    for (int i = 1; i < 1024; i++) sendWord(32'h0000_0000, i == 1023);
    waitIdle("R8");
    expStatus(8'h01, 16'd0, "R8");
    sendWord(32'hAA77_0011, 0);
    for (int i = 1; i < 1025; i++) sendWord(32'h0000_0000, i == 1024);
    waitIdle("R8");

    // R7 empty transaction
    expStatus(8'h00, 16'd0, "R7");
    sendWord(32'hAA77_0012, 1);
    waitIdle("R7");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule